// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block sequences the two gate enables of one channel of a current-mode step-down converter. Analog measurements arrive as comparator flags: sense versus the control level, sense versus a light-load level, the positive and negative current limits, feedback versus the reference, output versus a low-regulation level, switch node at zero, and inductor current at zero. An oscillator pulse marks each switching period. A mode input selects between fixed-frequency operation (`fpwm_mode` high) and pulse skipping (`fpwm_mode` low).

A high-side pulse starts on an oscillator pulse and ends on a sense flag. The low-side switch follows after an adaptive dead time: the switch node reaching zero ends it early, and a counter caps its length. A low-output override holds the high-side switch on until the output recovers. A supervisor fault input parks the channel with the low-side switch on. Dead time and minimum off time are given in picoseconds and turned into system-clock counts. With the defaults (8000 ps clock) the dead-time cap is 13 cycles and the minimum off time is 32 cycles.

Top module: `buck_gate_seq`

## Requirements
- R1: `hs_on` and `ls_on` are never high in the same cycle, and either one rises only after a cycle in which the other was low.
- R2: With `fpwm_mode`=1, an `osc_tick` sampled at a clock edge raises `hs_on` after that edge, provided the minimum off time has elapsed and both gates are off. `hs_on` falls after the first edge at which `cs_ctrl`=1, and `cs_light` has no effect.
- R3: After `hs_on` falls, both gates stay off until the switch-node flag `sw_zero` is sampled high. `ls_on` then rises one cycle after that sample. In any case `ls_on` rises no later than 13 cycles (the default cap) after `hs_on` fell.
- R4: With `fpwm_mode`=0, `il_zero`=1 turns `ls_on` off at the next edge and keeps it from turning on after a dead time. With `fpwm_mode`=1, `il_zero` has no effect.
- R5: With `fpwm_mode`=0, a pulse starts only at an `osc_tick` sampled while `fb_low`=1. It ends on `cs_light`=1, and `cs_ctrl` has no effect.
- R6: `ilim_pos`=1 while `hs_on` is high turns it off at the next edge. No new pulse starts before the next qualifying `osc_tick`.
- R7: `ilim_neg`=1 turns `ls_on` off at the next edge.
- R8: When `out_low`=1 and `startup`=0, `hs_on` is held high and `ls_on` low until `out_low` clears. With `startup`=1 the override has no effect. If `ls_on` is high when the override begins, one cycle with both gates off comes first.
- R9: `hs_on` starts a normal pulse only after it has been low for at least 32 cycles (the default).
- R10: `chan_en`=0 forces both gates off at the next edge and discards any pending pulse request. This takes priority over everything, including the fault input.
- R11: When `chan_en`=1 and `fault_force`=1, `hs_on` is off after the next edge. `ls_on` is on after that edge, or one edge later if `hs_on` was on. This overrides all switching requests.
- R12: During and right after reset, both gate enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; low parks both gates off |
| fault_force | input | 1 | Supervisor fault: high-side off, low-side on |
| fpwm_mode | input | 1 | 1 = fixed frequency, 0 = pulse skipping |
| startup | input | 1 | Inhibits the low-output override while high |
| osc_tick | input | 1 | One-cycle pulse at the start of each oscillator period |
| cs_ctrl | input | 1 | Sensed current has reached the control level |
| cs_light | input | 1 | Sensed current is above the light-load level |
| ilim_pos | input | 1 | Sensed current is above the positive limit |
| ilim_neg | input | 1 | Sensed current is below the negative limit |
| fb_low | input | 1 | Feedback is below the reference |
| out_low | input | 1 | Output is below the low-regulation level |
| sw_zero | input | 1 | Switch node has reached zero |
| il_zero | input | 1 | Inductor current has fallen to zero |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |

## Verification
The hardest case to reach from the ports is the minimum off time when it is longer than the dead time, with no low-side conduction in between. Only then does a start request wait in the idle state, where the off-time count alone decides the edge. The stimulus reaches it in skip mode: it ends a pulse on the light-load flag while `il_zero` is held high and keeps requests coming every cycle. The rise of `hs_on` then measures the off time exactly. Constrained-random traffic with rare enable drops and faults then checks that no request order produces overlapping gates.

// File: rtl/bgs_pkg.sv
package bgs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HIGH,
        ST_DEAD,
        ST_LOW,
        ST_GAP,
        ST_OVR,
        ST_BRK,
        ST_FLT
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       hs;
        logic       ls;
    } seq_regs_t;

    // Round a duration up to whole clock cycles, never below two.
    function automatic int cyc_ceil(input int dur_ps, input int per_ps);
        int c;
        c = (dur_ps + per_ps - 1) / per_ps;
        return (c < 2) ? 2 : c;
    endfunction

endpackage

// File: rtl/bgs_sat_timer.sv
module bgs_sat_timer #(
    parameter int LIMIT      = 13,
    parameter bit START_FULL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic done
);
    localparam int W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] TOP = W'(LIMIT - 1);

    logic [W-1:0] cnt_d, cnt_q;

    assign done = (cnt_q == TOP);

    always_comb begin
        if (clear)     cnt_d = '0;
        else if (done) cnt_d = cnt_q;
        else           cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= START_FULL ? TOP : '0;
        else        cnt_q <= cnt_d;
    end

    // R9 / R3: the count never runs past its ceiling
    a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clear) |=> done);

endmodule

// File: rtl/bgs_cycle_req.sv
module bgs_cycle_req (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic consume,
    input  logic osc_tick,
    input  logic fpwm_mode,
    input  logic fb_low,
    output logic req
);
    logic start;
    logic pend_d, pend_q;

    // fixed frequency: every tick; skipping: only ticks seen with feedback low
    assign start = osc_tick && (fpwm_mode || fb_low);
    assign req   = pend_q || start;

    always_comb begin
        if (flush || consume) pend_d = 1'b0;
        else                  pend_d = req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    // R10: a flushed request is gone on the following cycle
    a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !pend_q);

endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
    import bgs_pkg::*;
#(
    parameter int CLK_PS      = 8000,
    parameter int DEAD_MAX_PS = 100000,
    parameter int MIN_OFF_PS  = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chan_en,
    input  logic fault_force,
    input  logic fpwm_mode,
    input  logic startup,
    input  logic osc_tick,
    input  logic cs_ctrl,
    input  logic cs_light,
    input  logic ilim_pos,
    input  logic ilim_neg,
    input  logic fb_low,
    input  logic out_low,
    input  logic sw_zero,
    input  logic il_zero,
    output logic hs_on,
    output logic ls_on
);
    localparam int DEAD_CYC = cyc_ceil(DEAD_MAX_PS, CLK_PS);
    localparam int OFF_CYC  = cyc_ceil(MIN_OFF_PS, CLK_PS);

    seq_regs_t regs_d, regs_q;

    logic req, flush, consume;
    logic dt_done, off_done;
    logic ovr_req, hs_end, ls_block, norm_go, hs_state;

    assign hs_state = (regs_q.state == ST_HIGH) || (regs_q.state == ST_OVR);

    bgs_cycle_req u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .consume  (consume),
        .osc_tick (osc_tick),
        .fpwm_mode(fpwm_mode),
        .fb_low   (fb_low),
        .req      (req)
    );

    bgs_sat_timer #(.LIMIT(DEAD_CYC), .START_FULL(1'b0)) u_dead (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(regs_q.state != ST_DEAD),
        .done (dt_done)
    );

    bgs_sat_timer #(.LIMIT(OFF_CYC), .START_FULL(1'b1)) u_off (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(hs_state),
        .done (off_done)
    );

    assign ovr_req  = out_low && !startup && !ilim_pos;
    assign hs_end   = ilim_pos || (fpwm_mode ? cs_ctrl : cs_light);
    assign ls_block = ilim_neg || (!fpwm_mode && il_zero);
    assign norm_go  = req && off_done;

    always_comb begin
        seq_state_e nxt;
        nxt     = regs_q.state;
        flush   = 1'b0;
        consume = 1'b0;

        if (!chan_en) begin
            nxt   = ST_IDLE;
            flush = 1'b1;
        end else if (fault_force) begin
            flush = 1'b1;
            nxt   = hs_state ? ST_BRK : ST_FLT;
        end else begin
            unique case (regs_q.state)
                ST_IDLE: begin
                    if (ovr_req)      nxt = ST_OVR;
                    else if (norm_go) begin
                        nxt     = ST_HIGH;
                        consume = 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (ovr_req)     nxt = ST_OVR;
                    else if (hs_end) nxt = ST_DEAD;
                end
                ST_OVR: begin
                    flush = 1'b1;
                    if (!ovr_req) nxt = ST_DEAD;
                end
                ST_DEAD: begin
                    if (ovr_req) nxt = ST_OVR;
                    else if (norm_go) begin
                        nxt     = ST_HIGH;
                        consume = 1'b1;
                    end else if (sw_zero || dt_done) begin
                        nxt = ls_block ? ST_IDLE : ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (ovr_req || norm_go) nxt = ST_GAP;
                    else if (ls_block)      nxt = ST_IDLE;
                end
                ST_GAP: begin
                    if (ovr_req) nxt = ST_OVR;
                    else if (norm_go) begin
                        nxt     = ST_HIGH;
                        consume = 1'b1;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
                ST_BRK:  nxt = ST_IDLE;
                ST_FLT:  nxt = ST_LOW;
                default: nxt = ST_IDLE;
            endcase
        end

        regs_d.state = nxt;
        regs_d.hs    = (nxt == ST_HIGH) || (nxt == ST_OVR);
        regs_d.ls    = (nxt == ST_LOW) || (nxt == ST_FLT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.state <= ST_IDLE;
            regs_q.hs    <= 1'b0;
            regs_q.ls    <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign hs_on = regs_q.hs;
    assign ls_on = regs_q.ls;

    a_r1_ls_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_on) |-> !$past(hs_on));

    a_r1_hs_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_on) |-> !$past(ls_on));

    a_r10_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (!hs_on && !ls_on));

    a_r11_fault_hs_off: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && fault_force) |=> !hs_on);

    a_r9_min_off: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs_on) && regs_q.state == ST_HIGH) |-> $past(off_done));

    a_r3_dead_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && !fault_force && regs_q.state == ST_DEAD && dt_done)
        |=> (regs_q.state != ST_DEAD));

    a_r6_pos_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_HIGH && ilim_pos) |=> !hs_on);

    a_r7_neg_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == ST_LOW && ilim_neg && !fault_force) |=> !ls_on);

    a_r8_override_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && !fault_force && hs_on && ovr_req) |=> (hs_on && !ls_on));

endmodule

// File: tb/sim_buck_gate_seq.sv
module sim_buck_gate_seq;
    logic clk = 1'b0;
    logic rst_n, chan_en, fault_force, fpwm_mode, startup, osc_tick;
    logic cs_ctrl, cs_light, ilim_pos, ilim_neg, fb_low, out_low, sw_zero, il_zero;
    logic hs_on, ls_on;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    localparam int DT_EXP  = 13;
    localparam int OFF_EXP = 32;

    always #4 clk = ~clk;

    buck_gate_seq u0 (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .fault_force(fault_force),
        .fpwm_mode(fpwm_mode), .startup(startup), .osc_tick(osc_tick),
        .cs_ctrl(cs_ctrl), .cs_light(cs_light), .ilim_pos(ilim_pos),
        .ilim_neg(ilim_neg), .fb_low(fb_low), .out_low(out_low),
        .sw_zero(sw_zero), .il_zero(il_zero), .hs_on(hs_on), .ls_on(ls_on)
    );

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input logic act_h, input logic act_l,
                       input logic exp_h, input logic exp_l);
        n_chk++;
        if (act_h !== exp_h || act_l !== exp_l) begin
            n_bad++;
            $display("FAIL %s: hs/ls actual %b%b expected %b%b", req, act_h, act_l, exp_h, exp_l);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // steps until the chosen gate is high, capped
    task automatic wait_gate(input bit high_side, output int n, output bit ls_seen);
        n = 0;
        ls_seen = 1'b0;
        while (n < 100 && !(high_side ? hs_on : ls_on)) begin
            step();
            n++;
            if (ls_on) ls_seen = 1'b1;
        end
    endtask

    function automatic bit roll(input int one_in);
        return ($urandom % one_in) == 0;
    endfunction

    initial begin
        #(8ns * 200000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int n;
        bit seen;
        bit any;
        void'($urandom(32'h1bad5eed));
        rst_n = 0; chan_en = 0; fault_force = 0; fpwm_mode = 0; startup = 0;
        osc_tick = 0; cs_ctrl = 0; cs_light = 0; ilim_pos = 0; ilim_neg = 0;
        fb_low = 0; out_low = 0; sw_zero = 0; il_zero = 0;
        step(3);
        chk("R12 in reset", hs_on, ls_on, 0, 0);
        rst_n = 1; chan_en = 1; fpwm_mode = 1;
        step();
        chk("R12 after reset", hs_on, ls_on, 0, 0);

        // fixed-frequency pulse
        osc_tick = 1; step(); osc_tick = 0;
        chk("R2 tick starts pulse", hs_on, ls_on, 1, 0);
        cs_light = 1; step(3);
        chk("R2 light flag ignored", hs_on, ls_on, 1, 0);
        cs_light = 0; cs_ctrl = 1; step(); cs_ctrl = 0;
        chk("R2 control level ends pulse", hs_on, ls_on, 0, 0);
        wait_gate(1'b0, n, seen);
        chk_int("R3 dead time cap", n, DT_EXP);
        il_zero = 1; step(4);
        chk("R4 zero cross ignored in fixed mode", hs_on, ls_on, 0, 1);
        il_zero = 0;
        ilim_neg = 1; step(); ilim_neg = 0;
        chk("R7 negative limit", hs_on, ls_on, 0, 0);
        step(20);

        // early dead-time end
        osc_tick = 1; step(); osc_tick = 0;
        cs_ctrl = 1; sw_zero = 1; step();
        cs_ctrl = 0;
        chk("R3 hs off before ls", hs_on, ls_on, 0, 0);
        step(); sw_zero = 0;
        chk("R3 switch node zero ends dead time", hs_on, ls_on, 0, 1);
        step(40);

        // pulse from low-side conduction, then positive limit
        osc_tick = 1; step(); osc_tick = 0;
        chk("R1 gap before high side", hs_on, ls_on, 0, 0);
        step();
        chk("R2 pulse after gap", hs_on, ls_on, 1, 0);
        ilim_pos = 1; step(); ilim_pos = 0;
        chk("R6 positive limit ends pulse", hs_on, ls_on, 0, 0);
        any = 0;
        for (int i = 0; i < 60; i++) begin step(); if (hs_on) any = 1; end
        chk_int("R6 no restart without tick", int'(any), 0);

        // pulse skipping
        fpwm_mode = 0;
        osc_tick = 1; step(); osc_tick = 0; step();
        chk("R5 tick without low feedback", hs_on, ls_on, 0, 1);
        fb_low = 1; step(5);
        chk("R5 low feedback waits for tick", hs_on, ls_on, 0, 1);
        osc_tick = 1; step(); osc_tick = 0; step();
        chk("R5 pulse on tick with low feedback", hs_on, ls_on, 1, 0);
        fb_low = 0;
        cs_ctrl = 1; step();
        chk("R5 control level ignored in skip", hs_on, ls_on, 1, 0);
        cs_ctrl = 0; cs_light = 1; step(); cs_light = 0;
        chk("R5 light level ends pulse", hs_on, ls_on, 0, 0);
        il_zero = 1; fb_low = 1; osc_tick = 1;
        wait_gate(1'b1, n, seen);
        chk_int("R9 minimum off time", n, OFF_EXP);
        chk_int("R4 zero cross blocks low side", int'(seen), 0);
        osc_tick = 0; fb_low = 0;
        cs_light = 1; step(); cs_light = 0; il_zero = 0;
        step(5);
        wait_gate(1'b0, n, seen);
        il_zero = 1; step(); il_zero = 0;
        chk("R4 zero cross ends low side in skip", hs_on, ls_on, 0, 0);

        // low-output override
        startup = 1; out_low = 1;
        any = 0;
        for (int i = 0; i < 40; i++) begin step(); if (hs_on) any = 1; end
        chk_int("R8 override inhibited at startup", int'(any), 0);
        startup = 0; step();
        chk("R8 override begins", hs_on, ls_on, 1, 0);
        cs_ctrl = 1; cs_light = 1;
        any = 0;
        for (int i = 0; i < 50; i++) begin
            osc_tick = (i % 7 == 0); step();
            if (!hs_on || ls_on) any = 1;
        end
        osc_tick = 0;
        chk_int("R8 override holds high side", int'(any), 0);
        out_low = 0; cs_ctrl = 0; cs_light = 0; step();
        chk("R8 override release", hs_on, ls_on, 0, 0);

        // fault
        out_low = 1; step();
        chk("R8 override from dead time", hs_on, ls_on, 1, 0);
        fault_force = 1; step();
        chk("R11 fault drops high side", hs_on, ls_on, 0, 0);
        step();
        chk("R11 fault low side on", hs_on, ls_on, 0, 1);
        osc_tick = 1; step(5); osc_tick = 0;
        chk("R11 fault dominates override", hs_on, ls_on, 0, 1);
        fault_force = 0; out_low = 0; step();
        chk("R11 fault release", hs_on, ls_on, 0, 1);

        // disable
        chan_en = 0; step();
        chk("R10 disable", hs_on, ls_on, 0, 0);
        fpwm_mode = 1; osc_tick = 1; fault_force = 1; step(); osc_tick = 0; fault_force = 0;
        step();
        chk("R10 disable beats fault and tick", hs_on, ls_on, 0, 0);
        chan_en = 1; step(3);
        chk("R10 request discarded", hs_on, ls_on, 0, 0);

        // constrained random traffic
        begin
            logic ph, pl, pen, pflt;
            ph = hs_on; pl = ls_on;
            for (int i = 0; i < 6000; i++) begin
                chan_en     = !roll(60);
                fault_force = roll(50);
                if (roll(200)) fpwm_mode = ~fpwm_mode;
                startup     = roll(8);
                osc_tick    = roll(20);
                cs_ctrl     = roll(6);
                cs_light    = roll(5);
                ilim_pos    = roll(30);
                ilim_neg    = roll(30);
                fb_low      = roll(2);
                out_low     = roll(25);
                sw_zero     = roll(4);
                il_zero     = roll(10);
                pen = chan_en; pflt = fault_force;
                step();
                chk_int("R1 no overlap", int'(hs_on && ls_on), 0);
                if (ls_on && !pl) chk_int("R1 ls rise after gap", int'(ph), 0);
                if (hs_on && !ph) chk_int("R1 hs rise after gap", int'(pl), 0);
                if (!pen) chk("R10 random disable", hs_on, ls_on, 0, 0);
                else if (pflt) chk_int("R11 random fault", int'(hs_on), 0);
                ph = hs_on; pl = ls_on;
            end
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule